// File: doc/BRIEF.md
# Bus Match Comparator with Trace Buffer

This block is a passive observer placed beside two processor buses. Each bus carries a 23-bit address, 16-bit data, a write flag, a change-of-flow flag and a valid strobe. Four comparators (indices 0 to 3) look at the buses and raise breakpoint requests when an access matches. Comparators 0 and 2 check the address together with the data under a per-bit mask. Comparators 1 and 3 check only the address. Each comparator can be switched off, or set to match one address, an inclusive address window, or everything outside that window. A request is either immediate (force) or carried along with the access (tag). A tag request only fires when the processor reports that the access retired.

Selected accesses on one chosen bus are stored in a circular trace memory of 64 words of 64 bits. Tracing can capture every valid access, or only accesses flagged as change of flow. Software configures the comparators and reads the trace back through a small register port.

Top module: `bus_match_trace`

## Requirements
- R1: After reset, brkForce and brkTag are low, and the trace status register reads 0 (write pointer 0, wrapped flag clear).
- R2: Control register k (address k, k=0..3) holds the mode in bits [1:0] (0 off, 1 single match, 2 inside window, 3 outside window), the bus select in bit 2, and the request type in bit 3 (0 force, 1 tag). Comparator k's address lives at register 4+k, bits [22:0]. In single-match mode, comparator 0 (2) hits on a valid access of its bus whose address equals its address and whose data equals the value at register 8 (9) bits [15:0] in every bit set in the mask at bits [31:16].
- R3: Comparators 1 and 3 in single-match mode hit on address equality alone; data plays no part.
- R4: When comparator 0 (2) is in mode 2, it hits when the address on its bus lies between its own address (lower) and the address of comparator 1 (3) (upper), both inclusive. While the even comparator is in mode 2 or 3, the odd partner's own match is suppressed.
- R5: In mode 3 the even comparator hits when the address is below the lower bound or above the upper bound.
- R6: A comparator sees only the bus chosen by its select bit, never hits while that bus's valid is low, and never hits in mode 0.
- R7: A force-type hit drives brkForce high in the cycle after the matching access, for exactly one cycle per hit cycle.
- R8: A tag-type hit is held pending. brkTag pulses in the cycle after a retire input while the tag is pending. A flush input cancels the pending tag without any pulse, and a hit in the same cycle as retire does not fire until a later retire.
- R9: A traced access is stored as a 64-bit word: address in [22:0], data in [38:23], the write flag in [39], the source bus in [40], and zeros above.
- R10: Trace control (register 10) holds enable in bit 0, capture mode in bit 1 (1 every access, 0 change-of-flow only), and the traced bus in bit 2. Only valid accesses on the traced bus are stored, and in change-of-flow mode only those with the change-of-flow flag.
- R11: The write pointer advances by one per stored word and wraps from 63 to 0. Wrapping sets a sticky flag. Trace status (register 11) reads the pointer in bits [5:0] and the flag in bit 8. Any write to register 11 clears both.
- R12: Writing register 12 sets the read index (bits [5:0]). Registers 13 and 14 then return bits [31:0] and [63:32] of the stored word at that index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busValid | input | 2 | Access valid, one bit per bus |
| busAddr | input | 2x23 | Access address per bus |
| busData | input | 2x16 | Access data per bus |
| busWrite | input | 2 | Access is a write, per bus |
| busCof | input | 2 | Access is a change of flow, per bus |
| retire | input | 1 | Oldest tagged access completed |
| flush | input | 1 | Pending tagged access discarded |
| regWe | input | 1 | Register write strobe |
| regAddr | input | 4 | Register address |
| regWdata | input | 32 | Register write data |
| regRdata | output | 32 | Register read data (combinational) |
| brkForce | output | 1 | Immediate breakpoint request |
| brkTag | output | 1 | Breakpoint request of a retired tagged access |

## Verification
A wrong comparator setting or bound shows one cycle after the offending access, either as a missing or extra brkForce pulse or as a wrong brkTag once retire arrives. The bench therefore predicts both request outputs in every cycle. A corrupted pending tag stays hidden until the next retire or flush. A bad trace pointer or packing stays invisible until the status or a stored word is read back, so the bench reads status after each trace phase and reads entries just after they are written and after a wrap.

// File: rtl/bmt_pkg.sv
package bmt_pkg;
  localparam int AW = 23;
  localparam int DW = 16;
  localparam int NBUS = 2;
  localparam int NPAIR = 2;
  localparam int NCMP = 2 * NPAIR;
  localparam int RAW = 4;
  localparam int RDW = 32;

  localparam logic [RAW-1:0] RA_CTL0 = 4'd0;
  localparam logic [RAW-1:0] RA_ADR0 = 4'd4;
  localparam logic [RAW-1:0] RA_DAT0 = 4'd8;
  localparam logic [RAW-1:0] RA_TCTL = 4'd10;
  localparam logic [RAW-1:0] RA_TSTAT = 4'd11;
  localparam logic [RAW-1:0] RA_RIDX = 4'd12;
  localparam logic [RAW-1:0] RA_RLO = 4'd13;
  localparam logic [RAW-1:0] RA_RHI = 4'd14;

  typedef enum logic [1:0] {
    MODE_OFF = 2'd0,
    MODE_EQ  = 2'd1,
    MODE_IN  = 2'd2,
    MODE_OUT = 2'd3
  } cmpModeT;

  typedef struct packed {
    cmpModeT        mode;
    logic           bus;
    logic           tagType;
    logic [AW-1:0]  addr;
  } cmpCfgT;

  typedef struct packed {
    logic [DW-1:0] val;
    logic [DW-1:0] mask;
  } dataCfgT;

  typedef struct packed {
    logic en;
    logic every;
    logic bus;
  } trCfgT;

  typedef struct packed {
    logic trClr;
  } ctlStrbT;
endpackage

// File: rtl/bmt_ctrl.sv
module bmt_ctrl
  import bmt_pkg::*;
#(
  parameter int TR_DEPTH = 64,
  parameter int TR_W = 64,
  localparam int PW = $clog2(TR_DEPTH)
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    regWe,
  input  logic [RAW-1:0]          regAddr,
  input  logic [RDW-1:0]          regWdata,
  output logic [RDW-1:0]          regRdata,
  output cmpCfgT [NCMP-1:0]       cmpCfg,
  output dataCfgT [NPAIR-1:0]     dataCfg,
  output trCfgT                   trCfg,
  output ctlStrbT                 strb,
  output logic [PW-1:0]           rdIdx,
  input  logic [PW-1:0]           trPtr,
  input  logic                    trWrap,
  input  logic [TR_W-1:0]         trWord
);

  // configuration registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cmpCfg  <= '0;
      dataCfg <= '0;
      trCfg   <= '0;
      rdIdx   <= '0;
    end else if (regWe) begin
      for (int k = 0; k < NCMP; k++) begin
        if (regAddr == RAW'(RA_CTL0 + k)) begin
          cmpCfg[k].mode    <= cmpModeT'(regWdata[1:0]);
          cmpCfg[k].bus     <= regWdata[2];
          cmpCfg[k].tagType <= regWdata[3];
        end
        if (regAddr == RAW'(RA_ADR0 + k)) cmpCfg[k].addr <= regWdata[AW-1:0];
      end
      for (int p = 0; p < NPAIR; p++) begin
        if (regAddr == RAW'(RA_DAT0 + p)) begin
          dataCfg[p].val  <= regWdata[DW-1:0];
          dataCfg[p].mask <= regWdata[16+DW-1:16];
        end
      end
      if (regAddr == RA_TCTL) begin
        trCfg.en    <= regWdata[0];
        trCfg.every <= regWdata[1];
        trCfg.bus   <= regWdata[2];
      end
      if (regAddr == RA_RIDX) rdIdx <= regWdata[PW-1:0];
    end
  end

  // strobes toward the datapath
  always_comb begin
    strb = '0;
    strb.trClr = regWe && (regAddr == RA_TSTAT);
  end

  // read mux
  always_comb begin
    regRdata = '0;
    case (regAddr)
      RA_TSTAT: begin
        regRdata[PW-1:0] = trPtr;
        regRdata[8]      = trWrap;
      end
      RA_RIDX: regRdata = RDW'(rdIdx);
      RA_RLO:  regRdata = RDW'(trWord);
      RA_RHI:  regRdata = RDW'(trWord >> RDW);
      default: regRdata = '0;
    endcase
  end

endmodule

// File: rtl/bmt_datapath.sv
module bmt_datapath
  import bmt_pkg::*;
#(
  parameter int TR_DEPTH = 64,
  parameter int TR_W = 64,
  localparam int PW = $clog2(TR_DEPTH)
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic [NBUS-1:0]            busValid,
  input  logic [NBUS-1:0][AW-1:0]    busAddr,
  input  logic [NBUS-1:0][DW-1:0]    busData,
  input  logic [NBUS-1:0]            busWrite,
  input  logic [NBUS-1:0]            busCof,
  input  logic                       retire,
  input  logic                       flush,
  input  cmpCfgT [NCMP-1:0]          cmpCfg,
  input  dataCfgT [NPAIR-1:0]        dataCfg,
  input  trCfgT                      trCfg,
  input  ctlStrbT                    strb,
  input  logic [PW-1:0]              rdIdx,
  output logic                       brkForce,
  output logic                       brkTag,
  output logic [PW-1:0]              trPtr,
  output logic                       trWrap,
  output logic [TR_W-1:0]            trWord
);

  localparam logic [PW-1:0] LAST = PW'(TR_DEPTH - 1);

  logic [NCMP-1:0] hit;
  logic [NCMP-1:0] tagVec;
  logic            forceHit, tagHit, tagPend;

  // comparator pairs: even member is data-capable and owns the window
  for (genvar p = 0; p < NPAIR; p++) begin : g_pair
    localparam int LO = 2 * p;
    localparam int HI = 2 * p + 1;
    logic          loV, hiV, loEq, hiEq, inWin, rangeMode;
    logic [AW-1:0] loA, hiA;
    logic [DW-1:0] loD;

    assign loV = busValid[cmpCfg[LO].bus];
    assign loA = busAddr[cmpCfg[LO].bus];
    assign loD = busData[cmpCfg[LO].bus];
    assign hiV = busValid[cmpCfg[HI].bus];
    assign hiA = busAddr[cmpCfg[HI].bus];

    assign loEq = loV && (loA == cmpCfg[LO].addr) &&
                  (((loD ^ dataCfg[p].val) & dataCfg[p].mask) == '0);
    assign hiEq = hiV && (hiA == cmpCfg[HI].addr);
    assign inWin = (loA >= cmpCfg[LO].addr) && (loA <= cmpCfg[HI].addr);
    assign rangeMode = (cmpCfg[LO].mode == MODE_IN) || (cmpCfg[LO].mode == MODE_OUT);

    assign hit[LO] = (cmpCfg[LO].mode == MODE_EQ)  ? loEq :
                     (cmpCfg[LO].mode == MODE_IN)  ? (loV && inWin) :
                     (cmpCfg[LO].mode == MODE_OUT) ? (loV && !inWin) : 1'b0;
    assign hit[HI] = !rangeMode && (cmpCfg[HI].mode == MODE_EQ) && hiEq;
    assign tagVec[LO] = cmpCfg[LO].tagType;
    assign tagVec[HI] = cmpCfg[HI].tagType;
  end

  assign forceHit = |(hit & ~tagVec);
  assign tagHit   = |(hit & tagVec);

  // breakpoint requests
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      brkForce <= 1'b0;
      brkTag   <= 1'b0;
      tagPend  <= 1'b0;
    end else begin
      brkForce <= forceHit;
      brkTag   <= tagPend && retire && !flush;
      tagPend  <= tagHit || (tagPend && !retire && !flush);
    end
  end

  // trace capture
  logic            trSel, trHit;
  logic [TR_W-1:0] entry;
  logic [TR_W-1:0] mem [TR_DEPTH];

  assign trSel = trCfg.bus;
  assign trHit = trCfg.en && busValid[trSel] && (trCfg.every || busCof[trSel]);

  always_comb begin
    entry = '0;
    entry[AW-1:0]    = busAddr[trSel];
    entry[AW+DW-1:AW] = busData[trSel];
    entry[AW+DW]     = busWrite[trSel];
    entry[AW+DW+1]   = trSel;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      trPtr  <= '0;
      trWrap <= 1'b0;
    end else if (strb.trClr) begin
      trPtr  <= '0;
      trWrap <= 1'b0;
    end else if (trHit) begin
      trPtr <= (trPtr == LAST) ? '0 : trPtr + PW'(1);
      if (trPtr == LAST) trWrap <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (trHit && !strb.trClr) mem[trPtr] <= entry;
  end

  assign trWord = mem[rdIdx];

  // checks beside the logic
  p_force_from_access_r7: assert property (@(posedge clk) disable iff (!rstN)
    brkForce |-> $past(|busValid));

  p_tag_needs_retire_r8: assert property (@(posedge clk) disable iff (!rstN)
    brkTag |-> ($past(retire) && !$past(flush)));

  p_wrap_sticky_r11: assert property (@(posedge clk) disable iff (!rstN)
    (trWrap && !strb.trClr) |=> trWrap);

  p_ptr_wraps_r11: assert property (@(posedge clk) disable iff (!rstN)
    (trPtr == LAST && trHit && !strb.trClr) |=> (trPtr == '0 && trWrap));

  p_ptr_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    (!trHit && !strb.trClr) |=> $stable(trPtr));

endmodule

// File: rtl/bus_match_trace.sv
module bus_match_trace
  import bmt_pkg::*;
#(
  parameter int TR_DEPTH = 64,
  parameter int TR_W = 64
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic [NBUS-1:0]          busValid,
  input  logic [NBUS-1:0][AW-1:0]  busAddr,
  input  logic [NBUS-1:0][DW-1:0]  busData,
  input  logic [NBUS-1:0]          busWrite,
  input  logic [NBUS-1:0]          busCof,
  input  logic                     retire,
  input  logic                     flush,
  input  logic                     regWe,
  input  logic [RAW-1:0]           regAddr,
  input  logic [RDW-1:0]           regWdata,
  output logic [RDW-1:0]           regRdata,
  output logic                     brkForce,
  output logic                     brkTag
);
  localparam int PW = $clog2(TR_DEPTH);

  cmpCfgT [NCMP-1:0]   cmpCfg;
  dataCfgT [NPAIR-1:0] dataCfg;
  trCfgT               trCfg;
  ctlStrbT             strb;
  logic [PW-1:0]       rdIdx, trPtr;
  logic                trWrap;
  logic [TR_W-1:0]     trWord;

  bmt_ctrl #(.TR_DEPTH(TR_DEPTH), .TR_W(TR_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr), .regWdata(regWdata),
    .regRdata(regRdata), .cmpCfg(cmpCfg), .dataCfg(dataCfg), .trCfg(trCfg),
    .strb(strb), .rdIdx(rdIdx), .trPtr(trPtr), .trWrap(trWrap), .trWord(trWord)
  );

  bmt_datapath #(.TR_DEPTH(TR_DEPTH), .TR_W(TR_W)) dp_i (
    .clk(clk), .rstN(rstN), .busValid(busValid), .busAddr(busAddr), .busData(busData),
    .busWrite(busWrite), .busCof(busCof), .retire(retire), .flush(flush),
    .cmpCfg(cmpCfg), .dataCfg(dataCfg), .trCfg(trCfg), .strb(strb), .rdIdx(rdIdx),
    .brkForce(brkForce), .brkTag(brkTag), .trPtr(trPtr), .trWrap(trWrap), .trWord(trWord)
  );
endmodule

// File: tb/bus_match_trace_tb_top.sv
module bus_match_trace_tb_top;
  timeunit 1ns;
  timeprecision 100ps;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #2.5 clk = ~clk;

  logic [1:0]       bValid, bWrite, bCof;
  logic [1:0][22:0] bAddr;
  logic [1:0][15:0] bData;
  logic             retire, flush, regWe;
  logic [3:0]       regAddr;
  logic [31:0]      regWdata, regRdata;
  logic             brkForce, brkTag;

  bus_match_trace dut_i (
    .clk(clk), .rstN(rstN), .busValid(bValid), .busAddr(bAddr), .busData(bData),
    .busWrite(bWrite), .busCof(bCof), .retire(retire), .flush(flush),
    .regWe(regWe), .regAddr(regAddr), .regWdata(regWdata), .regRdata(regRdata),
    .brkForce(brkForce), .brkTag(brkTag)
  );

  int errors = 0;
  int checks = 0;

  typedef struct { logic f; logic t; string why; } expT;
  expT q[$];

  // reference model state
  logic [1:0]  mMode [4];
  logic        mBus [4];
  logic        mTag [4];
  logic [22:0] mAdr [4];
  logic [15:0] mVal [2];
  logic [15:0] mMask [2];
  logic        tEn, tEvery, tBus, mPend, mWrap;
  int          mPtr;
  logic [63:0] mMem [64];

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // scoreboard monitor
  always @(posedge clk) begin : mon
    expT e;
    #1;
    if (q.size() > 0) begin
      e = q.pop_front();
      chk({e.why, " brkForce"}, {63'b0, brkForce}, {63'b0, e.f});
      chk({e.why, " brkTag"},   {63'b0, brkTag},   {63'b0, e.t});
    end
  end

  function automatic logic mHit(int k);
    int b;
    b = int'(mBus[k]);
    if (k % 2 == 0) begin
      case (mMode[k])
        2'd1: return bValid[b] && bAddr[b] == mAdr[k] &&
                     ((bData[b] ^ mVal[k/2]) & mMask[k/2]) == 16'h0;
        2'd2: return bValid[b] && bAddr[b] >= mAdr[k] && bAddr[b] <= mAdr[k+1];
        2'd3: return bValid[b] && (bAddr[b] < mAdr[k] || bAddr[b] > mAdr[k+1]);
        default: return 1'b0;
      endcase
    end
    if (mMode[k-1][1]) return 1'b0;
    return mMode[k] == 2'd1 && bValid[b] && bAddr[b] == mAdr[k];
  endfunction

  // driver: predicts this cycle's outcome, pushes it, advances one clock
  task automatic cyc(string why);
    logic f = 1'b0;
    logic t = 1'b0;
    expT  e;
    for (int k = 0; k < 4; k++) if (mHit(k)) begin
      if (mTag[k]) t = 1'b1; else f = 1'b1;
    end
    e.f = f;
    e.t = mPend && retire && !flush;
    e.why = why;
    q.push_back(e);
    mPend = t || (mPend && !retire && !flush);
    if (regWe && regAddr == 4'd11) begin
      mPtr = 0; mWrap = 1'b0;
    end else if (tEn && bValid[tBus] && (tEvery || bCof[tBus])) begin
      mMem[mPtr] = {23'b0, tBus, bWrite[tBus], bData[tBus], bAddr[tBus]};
      if (mPtr == 63) begin mPtr = 0; mWrap = 1'b1; end else mPtr++;
    end
    if (regWe) begin
      if (regAddr < 4) begin
        mMode[regAddr] = regWdata[1:0];
        mBus[regAddr]  = regWdata[2];
        mTag[regAddr]  = regWdata[3];
      end else if (regAddr < 8) mAdr[regAddr-4] = regWdata[22:0];
      else if (regAddr < 10) begin
        mVal[regAddr-8]  = regWdata[15:0];
        mMask[regAddr-8] = regWdata[31:16];
      end else if (regAddr == 4'd10) begin
        tEn = regWdata[0]; tEvery = regWdata[1]; tBus = regWdata[2];
      end
    end
    @(posedge clk);
    @(negedge clk);
    bValid = '0; bWrite = '0; bCof = '0; retire = 1'b0; flush = 1'b0; regWe = 1'b0;
  endtask

  task automatic wr(logic [3:0] a, logic [31:0] d);
    regWe = 1'b1; regAddr = a; regWdata = d;
    cyc($sformatf("reg write %0d", a));
  endtask

  task automatic acc(int b, logic [22:0] a, logic [15:0] d, logic w, logic c, string why);
    bValid[b] = 1'b1; bAddr[b] = a; bData[b] = d; bWrite[b] = w; bCof[b] = c;
    cyc(why);
  endtask

  task automatic rd(string req, logic [3:0] a, logic [31:0] exp);
    regAddr = a;
    #0.5;
    chk(req, {32'b0, regRdata}, {32'b0, exp});
  endtask

  task automatic rdStatus(string req);
    rd(req, 4'd11, (mWrap ? 32'h100 : 32'h0) | 32'(mPtr));
  endtask

  task automatic rdEntry(string req, int idx);
    wr(4'd12, 32'(idx));
    rd(req, 4'd13, mMem[idx][31:0]);
    rd(req, 4'd14, mMem[idx][63:32]);
  endtask

  initial begin
    #1000000;
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    bValid = '0; bWrite = '0; bCof = '0; bAddr = '0; bData = '0;
    retire = 1'b0; flush = 1'b0; regWe = 1'b0; regAddr = '0; regWdata = '0;
    for (int k = 0; k < 4; k++) begin
      mMode[k] = 2'd0; mBus[k] = 1'b0; mTag[k] = 1'b0; mAdr[k] = '0;
    end
    mVal[0] = '0; mVal[1] = '0; mMask[0] = '0; mMask[1] = '0;
    tEn = 1'b0; tEvery = 1'b0; tBus = 1'b0; mPend = 1'b0; mWrap = 1'b0; mPtr = 0;
    for (int i = 0; i < 64; i++) mMem[i] = '0;

    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 brkForce after reset", {63'b0, brkForce}, 64'd0);
    chk("R1 brkTag after reset", {63'b0, brkTag}, 64'd0);
    rd("R1 status after reset", 4'd11, 32'h0);

    // R2 comparator 0: low byte compared only, bus 0, force
    wr(4'd8, {16'h00FF, 16'h00AB});
    wr(4'd4, 32'h100);
    wr(4'd0, 32'h1);
    acc(0, 23'h100, 16'h12AB, 1'b0, 1'b0, "R2 masked data hit");
    cyc("R7 force pulse lasts one cycle");
    acc(0, 23'h100, 16'h12AC, 1'b0, 1'b0, "R2 compared bit differs");
    acc(1, 23'h100, 16'h12AB, 1'b0, 1'b0, "R6 access on other bus");
    acc(0, 23'h101, 16'h12AB, 1'b0, 1'b0, "R2 address differs");
    acc(0, 23'h100, 16'h00AB, 1'b0, 1'b0, "R7 back to back hit 1");
    acc(0, 23'h100, 16'hFFAB, 1'b0, 1'b0, "R7 back to back hit 2");
    bAddr[0] = 23'h100; bData[0] = 16'h00AB;
    cyc("R6 valid low no hit");

    // R3 / R8 comparator 1: address only, bus 1, tag
    wr(4'd5, 32'h200);
    wr(4'd1, 32'hD);
    acc(1, 23'h200, 16'hFFFF, 1'b0, 1'b0, "R3 address-only hit, tag pending");
    cyc("R8 pending holds without retire");
    retire = 1'b1;
    cyc("R8 tag fires after retire");
    acc(1, 23'h200, 16'h0000, 1'b0, 1'b0, "R3 second hit any data");
    flush = 1'b1;
    cyc("R8 flush cancels");
    retire = 1'b1;
    cyc("R8 no tag after flush");
    retire = 1'b1;
    acc(1, 23'h200, 16'h1234, 1'b0, 1'b0, "R8 hit with retire same cycle");
    cyc("R8 still pending");
    retire = 1'b1;
    cyc("R8 later retire fires");

    // R2 comparator 2: full mask, bus 1, force
    wr(4'd9, {16'hFFFF, 16'h5A5A});
    wr(4'd6, 32'h300);
    wr(4'd2, 32'h5);
    acc(1, 23'h300, 16'h5A5A, 1'b0, 1'b0, "R2 comparator 2 exact");
    acc(1, 23'h300, 16'h5A5B, 1'b0, 1'b0, "R2 comparator 2 data miss");
    acc(0, 23'h300, 16'h5A5A, 1'b0, 1'b0, "R6 comparator 2 wrong bus");

    // R4 inside window on pair 0/1
    wr(4'd4, 32'h1000);
    wr(4'd5, 32'h1FFF);
    wr(4'd0, 32'h2);
    acc(1, 23'h1FFF, 16'h0, 1'b0, 1'b0, "R4 odd partner suppressed");
    acc(0, 23'h1000, 16'h0, 1'b0, 1'b0, "R4 lower bound inclusive");
    acc(0, 23'h1FFF, 16'h0, 1'b0, 1'b0, "R4 upper bound inclusive");
    acc(0, 23'h0FFF, 16'h0, 1'b0, 1'b0, "R4 below window");
    acc(0, 23'h2000, 16'h0, 1'b0, 1'b0, "R4 above window");

    // R5 outside window
    wr(4'd0, 32'h3);
    acc(0, 23'h0FFF, 16'h0, 1'b0, 1'b0, "R5 below hits");
    acc(0, 23'h2000, 16'h0, 1'b0, 1'b0, "R5 above hits");
    acc(0, 23'h1000, 16'h0, 1'b0, 1'b0, "R5 lower bound misses");
    acc(0, 23'h1800, 16'h0, 1'b0, 1'b0, "R5 inside misses");

    // R6 off mode
    wr(4'd0, 32'h0);
    wr(4'd1, 32'h0);
    wr(4'd2, 32'h0);
    acc(0, 23'h1800, 16'h0, 1'b0, 1'b0, "R6 mode off");
    acc(1, 23'h300, 16'h5A5A, 1'b0, 1'b0, "R6 comparator 2 off");

    // R9 / R10 trace every access on bus 0
    wr(4'd11, 32'h0);
    wr(4'd10, 32'h3);
    acc(0, 23'h123, 16'hBEEF, 1'b1, 1'b0, "R9 trace write access");
    acc(0, 23'h7FFFFF, 16'h0001, 1'b0, 1'b1, "R9 trace read access");
    acc(1, 23'h55, 16'h55, 1'b1, 1'b1, "R10 other bus not traced");
    rdStatus("R11 pointer after two stores");
    rdEntry("R9 entry 0 format", 0);
    rdEntry("R9 entry 1 format", 1);

    // R10 change-of-flow only on bus 1
    wr(4'd10, 32'h5);
    acc(1, 23'h10, 16'h1, 1'b0, 1'b0, "R10 plain access skipped");
    acc(1, 23'h20, 16'h2, 1'b1, 1'b1, "R10 change of flow stored");
    rdStatus("R10 pointer advanced once");
    rdEntry("R10 stored bus 1 entry", 2);
    wr(4'd10, 32'h4);
    acc(1, 23'h30, 16'h3, 1'b0, 1'b1, "R10 disabled trace");
    rdStatus("R10 pointer held while disabled");

    // R11 wrap
    wr(4'd11, 32'h0);
    wr(4'd10, 32'h3);
    for (int i = 0; i < 64; i++)
      acc(0, 23'(i * 3 + 7), 16'(i * 257), 1'(i), 1'b0, "R11 fill");
    rdStatus("R11 wrapped to 0 with flag");
    acc(0, 23'h4444, 16'h9999, 1'b1, 1'b0, "R11 overwrite oldest");
    rdStatus("R11 flag sticky after wrap");
    rdEntry("R11 entry 0 overwritten", 0);
    rdEntry("R12 entry 63 readback", 63);
    wr(4'd11, 32'h0);
    rdStatus("R11 clear by status write");
    rd("R12 read index register", 4'd12, 32'd63);

    repeat (2) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule